// File: doc/BRIEF.md
# Configurable SPI Master Frame Engine

This block is the bus side of a single-master SPI port. A host asks for one frame at a time. It presents a transmit word, a frame length, the clock polarity and phase, and two divisor values, then pulses a start request. The engine drives the active-low select, toggles SCLK, and shifts MOSI out and MISO in together, most significant bit first. When the last bit is in, it raises select, returns the received word right-aligned, and pulses done for one cycle.

SCLK comes from the system clock through two counters in series. The first divides by half of an even prescale value. The second divides by the serial clock rate plus one. Each SCLK half period is therefore (prescale/2)*(rate+1) system clocks. The engine adjusts the settings so that a bit never takes fewer than eight system clocks. Configuration is sampled on the accepted start request and held for the whole frame.

The controller has four states. IDLE waits for a start request and leaves on it (IDLE->LEAD). LEAD holds select low for one half period with SCLK at rest, then makes the first SCLK edge (LEAD->SHIFT). SHIFT makes the remaining edges, one per half period, and one half period after the last edge it leaves (SHIFT->FINISH). FINISH lasts one cycle: done is high and select is already released. It always returns to IDLE (FINISH->IDLE).

Top module: `spi_frame_master`

## Requirements
- R1: After reset and whenever no frame is running, select is high, busy is low, done is low, MOSI is low, and SCLK equals the polarity input (one cycle later).
- R2: A frame exchanges words full duplex, MSB first. Bit n-1 of the transmit word goes out first. The received word comes back right-aligned in the 16-bit output with all bits at n and above zero, valid in the cycle done is high.
- R3: All four clock modes work. Polarity 0 rests SCLK low and polarity 1 rests it high. With phase 0 MISO is sampled on odd edges (1st, 3rd, ...) and MOSI changes on even edges. With phase 1 MISO is sampled on even edges and MOSI changes on odd edges.
- R4: The frame length input is taken in the range 4..16. A value below 4 acts as 4 and a value above 16 acts as 16.
- R5: The SCLK half period is (P/2)*(S+1) system clocks, with S the rate input. P is the prescale input rounded up to an even number, and any value below 2 becomes 2.
- R6: A bit is never shorter than 8 system clocks. P is raised to at least 8 when S=0, and to at least 4 when S is 1 or 2.
- R7: With phase 0, the first MOSI bit is valid in the first cycle select is low, before any SCLK edge.
- R8: Select stays low for the whole frame. SCLK makes exactly 2n edges while select is low and is back at its rest level when select rises.
- R9: Busy goes high the cycle after an accepted start and stays high through the single-cycle done pulse. It is low the following cycle. A start request while busy is high, including during the done cycle, is ignored.
- R10: MOSI never changes in the cycle in which SCLK makes a sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame request, sampled while idle |
| tx_word_i | input | 16 | Transmit word, right-aligned |
| frame_len_i | input | 5 | Bits per frame (4..16) |
| cpol_i | input | 1 | SCLK rest level |
| cpha_i | input | 1 | 0: sample on odd edges, 1: sample on even edges |
| prescale_i | input | 8 | First-stage divisor (even) |
| scr_i | input | 8 | Second-stage divisor minus one |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| miso_i | input | 1 | Serial data from the slave |
| ss_n_o | output | 1 | Active-low slave select |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle frame completion pulse |
| rx_word_o | output | 16 | Received word, right-aligned, zero-extended |

## Verification
Two events can fall on the same clock here: the done pulse of one frame and a new start request from the host. The bench holds start high during the very cycle done is seen. It then checks that busy is low and select is still high on the next cycle, so that request was dropped and no second frame began. A slave model in the bench answers on the SCLK edges of each mode. Its received bits, its edge count and the measured edge spacing are compared with values computed from the requirements.

// File: rtl/spi_mst_pkg.sv
package spi_mst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LEAD   = 2'd1,
        ST_SHIFT  = 2'd2,
        ST_FINISH = 2'd3
    } spi_state_e;
endpackage

// File: rtl/spi_cfg_norm.sv
module spi_cfg_norm #(
    parameter int MIN_BITS = 4,
    parameter int MAX_BITS = 16,
    parameter int LEN_W    = 5,
    parameter int PRE_W    = 8,
    parameter int SCR_W    = 8
) (
    input  logic [LEN_W-1:0] len_i,
    input  logic [PRE_W-1:0] prescale_i,
    input  logic [SCR_W-1:0] scr_i,
    output logic [LEN_W-1:0] len_o,
    output logic [PRE_W:0]   half_pre_o
);
    localparam logic [LEN_W-1:0] LEN_LO = LEN_W'(MIN_BITS);
    localparam logic [LEN_W-1:0] LEN_HI = LEN_W'(MAX_BITS);

    logic [PRE_W:0] pre_even;

    always_comb begin
        if (len_i < LEN_LO)      len_o = LEN_LO;
        else if (len_i > LEN_HI) len_o = LEN_HI;
        else                     len_o = len_i;
    end

    // round odd up, floor at 2, then raise so a bit spans >= 8 clocks
    always_comb begin
        pre_even = {1'b0, prescale_i} + {{PRE_W{1'b0}}, prescale_i[0]};
        if (pre_even < (PRE_W+1)'(2))
            pre_even = (PRE_W+1)'(2);
        if (scr_i == '0) begin
            if (pre_even < (PRE_W+1)'(8)) pre_even = (PRE_W+1)'(8);
        end else if (scr_i <= SCR_W'(2)) begin
            if (pre_even < (PRE_W+1)'(4)) pre_even = (PRE_W+1)'(4);
        end
        half_pre_o = pre_even >> 1;
    end
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
    parameter int PRE_W = 8,
    parameter int SCR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [PRE_W:0]   half_pre_i,
    input  logic [SCR_W-1:0] scr_i,
    output logic             tick_o
);
    logic [PRE_W:0]   pre_cnt;
    logic [SCR_W-1:0] scr_cnt;
    logic             pre_wrap;

    assign pre_wrap = (pre_cnt == half_pre_i - 1'b1);
    assign tick_o   = run_i && pre_wrap && (scr_cnt == scr_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            scr_cnt <= '0;
        end else if (!run_i) begin
            pre_cnt <= '0;
            scr_cnt <= '0;
        end else if (pre_wrap) begin
            pre_cnt <= '0;
            scr_cnt <= (scr_cnt == scr_i) ? '0 : scr_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    // independent gap counter: half period is never below 4 clocks
    logic [2:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                gap_q <= '0;
        else if (!run_i || tick_o) gap_q <= '0;
        else if (gap_q != 3'd7)    gap_q <= gap_q + 1'b1;
    end

    p_bit_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> gap_q >= 3'd3);
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
    parameter int MAX_BITS = 16,
    parameter int LEN_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [MAX_BITS-1:0] tx_i,
    input  logic [LEN_W-1:0]    load_len_i,
    input  logic [LEN_W-1:0]    len_i,
    input  logic                capture_i,
    input  logic                shift_i,
    input  logic                miso_i,
    output logic                mosi_bit_o,
    output logic [MAX_BITS-1:0] rx_next_o
);
    logic [MAX_BITS-1:0] sr_q;
    logic                held_q;
    logic                pend_q;
    logic [MAX_BITS-1:0] mask;
    logic [MAX_BITS-1:0] flushed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '0;
            held_q <= 1'b0;
            pend_q <= 1'b0;
        end else if (load_i) begin
            sr_q   <= tx_i << (LEN_W'(MAX_BITS) - load_len_i);
            pend_q <= 1'b0;
        end else if (capture_i) begin
            held_q <= miso_i;
            pend_q <= 1'b1;
        end else if (shift_i && pend_q) begin
            sr_q   <= {sr_q[MAX_BITS-2:0], held_q};
            pend_q <= 1'b0;
        end
    end

    always_comb begin
        for (int i = 0; i < MAX_BITS; i++)
            mask[i] = (i < int'(len_i));
    end

    assign flushed    = pend_q ? {sr_q[MAX_BITS-2:0], held_q} : sr_q;
    assign rx_next_o  = flushed & mask;
    assign mosi_bit_o = sr_q[MAX_BITS-1];

    // a second sample before the first was shifted in would lose a bit
    p_no_lost_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        capture_i |-> !pend_q);
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
    import spi_mst_pkg::*;
#(
    parameter int MIN_BITS = 4,
    parameter int MAX_BITS = 16,
    parameter int LEN_W    = $clog2(MAX_BITS + 1),
    parameter int PRE_W    = 8,
    parameter int SCR_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [MAX_BITS-1:0] tx_word_i,
    input  logic [LEN_W-1:0]    frame_len_i,
    input  logic                cpol_i,
    input  logic                cpha_i,
    input  logic [PRE_W-1:0]    prescale_i,
    input  logic [SCR_W-1:0]    scr_i,
    output logic                sclk_o,
    output logic                mosi_o,
    input  logic                miso_i,
    output logic                ss_n_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [MAX_BITS-1:0] rx_word_o
);
    localparam int CNT_W = LEN_W + 1;

    spi_state_e          state_q, state_d;
    logic                cpol_q, cpha_q;
    logic [LEN_W-1:0]    len_q, len_n;
    logic [PRE_W:0]      hpre_q, hpre_n;
    logic [SCR_W-1:0]    scr_q;
    logic [CNT_W-1:0]    edge_q;
    logic [CNT_W-1:0]    edges_total;
    logic                run, tick, start_ok;
    logic                edge_now, end_now, lead_edge, capture, shift_en;
    logic                mosi_bit;
    logic [MAX_BITS-1:0] rx_next;

    spi_cfg_norm #(
        .MIN_BITS(MIN_BITS), .MAX_BITS(MAX_BITS), .LEN_W(LEN_W),
        .PRE_W(PRE_W), .SCR_W(SCR_W)
    ) u_norm (
        .len_i(frame_len_i), .prescale_i(prescale_i), .scr_i(scr_i),
        .len_o(len_n), .half_pre_o(hpre_n)
    );

    assign run = (state_q == ST_LEAD) || (state_q == ST_SHIFT);

    spi_clk_div #(.PRE_W(PRE_W), .SCR_W(SCR_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run_i(run),
        .half_pre_i(hpre_q), .scr_i(scr_q), .tick_o(tick)
    );

    assign start_ok    = (state_q == ST_IDLE) && start_i;
    assign edges_total = {len_q, 1'b0};
    assign edge_now    = tick && ((state_q == ST_LEAD) ||
                         ((state_q == ST_SHIFT) && (edge_q < edges_total)));
    assign end_now     = tick && (state_q == ST_SHIFT) && (edge_q == edges_total);
    assign lead_edge   = ~edge_q[0];
    assign capture     = edge_now && (cpha_q ? !lead_edge : lead_edge);
    assign shift_en    = edge_now && !capture;

    spi_shifter #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .load_i(start_ok), .tx_i(tx_word_i), .load_len_i(len_n),
        .len_i(len_q), .capture_i(capture), .shift_i(shift_en),
        .miso_i(miso_i), .mosi_bit_o(mosi_bit), .rx_next_o(rx_next)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_LEAD;
            ST_LEAD:   if (tick)    state_d = ST_SHIFT;
            ST_SHIFT:  if (end_now) state_d = ST_FINISH;
            ST_FINISH:              state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // outputs and frame configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ss_n_o    <= 1'b1;
            sclk_o    <= 1'b0;
            done_o    <= 1'b0;
            rx_word_o <= '0;
            cpol_q    <= 1'b0;
            cpha_q    <= 1'b0;
            len_q     <= LEN_W'(MIN_BITS);
            hpre_q    <= (PRE_W+1)'(1);
            scr_q     <= '0;
            edge_q    <= '0;
        end else begin
            done_o <= end_now;
            if (state_q == ST_IDLE) begin
                sclk_o <= cpol_i;
                if (start_i) begin
                    ss_n_o <= 1'b0;
                    cpol_q <= cpol_i;
                    cpha_q <= cpha_i;
                    len_q  <= len_n;
                    hpre_q <= hpre_n;
                    scr_q  <= scr_i;
                    edge_q <= '0;
                end
            end
            if (edge_now) begin
                sclk_o <= ~sclk_o;
                edge_q <= edge_q + 1'b1;
            end
            if (end_now) begin
                ss_n_o    <= 1'b1;
                rx_word_o <= rx_next;
            end
        end
    end

    assign busy_o = (state_q != ST_IDLE);
    assign mosi_o = ss_n_o ? 1'b0 : mosi_bit;

    p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (ss_n_o && !done_o));
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);
    p_edge_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_n_o |-> edge_q <= edges_total);
    p_sclk_rest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_n_o) |-> sclk_o == cpol_q);
    p_mosi_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ss_n_o && !$past(ss_n_o) && (sclk_o != $past(sclk_o)) &&
         (sclk_o == ~(cpol_q ^ cpha_q))) |-> (mosi_o == $past(mosi_o)));
endmodule

// File: tb/sim_spi_frame_master.sv
module sim_spi_frame_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] tx_word_i = '0;
    logic [4:0]  frame_len_i = 5'd8;
    logic        cpol_i = 1'b0, cpha_i = 1'b0;
    logic [7:0]  prescale_i = 8'd2, scr_i = 8'd3;
    logic        sclk_o, mosi_o, ss_n_o, busy_o, done_o;
    logic [15:0] rx_word_o;
    logic        miso_r = 1'b0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    spi_frame_master u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tx_word_i(tx_word_i),
        .frame_len_i(frame_len_i), .cpol_i(cpol_i), .cpha_i(cpha_i),
        .prescale_i(prescale_i), .scr_i(scr_i), .sclk_o(sclk_o),
        .mosi_o(mosi_o), .miso_i(miso_r), .ss_n_o(ss_n_o), .busy_o(busy_o),
        .done_o(done_o), .rx_word_o(rx_word_o)
    );

    // slave model
    logic        s_cpha = 1'b0;
    logic [15:0] s_word = '0;
    logic [15:0] s_sh = '0, s_rx = '0;
    int          s_len = 8;
    int          s_ec = 0;

    always @(negedge ss_n_o) begin
        s_ec = 0;
        s_rx = '0;
        s_sh = s_word << (16 - s_len);
        if (!s_cpha) miso_r = s_sh[15];
    end

    always @(sclk_o) begin
        if (ss_n_o === 1'b0) begin
            s_ec++;
            if (s_cpha ? (s_ec % 2 == 0) : (s_ec % 2 == 1))
                s_rx = {s_rx[14:0], mosi_o};
            else if (s_cpha && s_ec == 1)
                miso_r = s_sh[15];
            else begin
                s_sh = {s_sh[14:0], 1'b0};
                miso_r = s_sh[15];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_half(input int pre, input int scr);
        int p;
        p = (pre % 2 == 1) ? pre + 1 : pre;
        if (p < 2) p = 2;
        if (scr == 0 && p < 8) p = 8;
        else if (scr >= 1 && scr <= 2 && p < 4) p = 4;
        return (p / 2) * (scr + 1);
    endfunction

    function automatic int eff_len(input int n);
        if (n < 4) return 4;
        if (n > 16) return 16;
        return n;
    endfunction

    // one frame with full monitoring; mid_start pulses a second request
    task automatic run_frame(input string req, input bit pol, input bit pha,
                             input int len, input logic [15:0] tx,
                             input logic [15:0] sw, input int pre, input int scr,
                             input bit mid_start);
        int n, h, cyc, last, bad_gap, gap_seen, ss_rose, dones;
        logic [15:0] mask, prev_sclk;
        n = eff_len(len);
        h = exp_half(pre, scr);
        mask = 16'((32'd1 << n) - 1);
        @(negedge clk);
        cpol_i = pol; cpha_i = pha; frame_len_i = 5'(len);
        prescale_i = 8'(pre); scr_i = 8'(scr); tx_word_i = tx;
        s_cpha = pha; s_word = sw; s_len = n;
        @(negedge clk);
        chk(sclk_o == pol, "R3", "idle sclk level", sclk_o, pol);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(!ss_n_o && busy_o, "R9", "select/busy after start", {ss_n_o, busy_o}, 1);
        if (!pha)
            chk(mosi_o == tx[n-1] && sclk_o == pol, "R7", "first bit before edge",
                mosi_o, tx[n-1]);
        cyc = 0; last = -1; bad_gap = 0; gap_seen = 0; ss_rose = 0; dones = 0;
        prev_sclk = {15'd0, sclk_o};
        while (!done_o && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (mid_start && cyc == 5) start_i = 1'b1;
            if (mid_start && cyc == 6) begin
                start_i = 1'b0;
                tx_word_i = ~tx;
            end
            if (sclk_o != prev_sclk[0]) begin
                if (last >= 0) begin
                    gap_seen = cyc - last;
                    if (gap_seen != h) bad_gap = gap_seen;
                end
                last = cyc;
                prev_sclk[0] = sclk_o;
            end
            if (ss_n_o && !done_o) ss_rose = 1;
        end
        chk(done_o == 1'b1, "R9", "done seen", done_o, 1);
        chk(bad_gap == 0, "R5", "sclk half period", bad_gap, h);
        chk(s_ec == 2 * n, "R8", "edge count", s_ec, 2 * n);
        chk(ss_rose == 0 && ss_n_o, "R8", "select low for frame only", ss_rose, 0);
        chk(rx_word_o == (sw & mask), "R2", "master received word", rx_word_o, sw & mask);
        chk((s_rx & mask) == (tx & mask), "R3", "slave received word", s_rx & mask, tx & mask);
        chk((rx_word_o & ~mask) == 0, "R4", "upper bits zero", rx_word_o & ~mask, 0);
        @(negedge clk);
        chk(!done_o && !busy_o, "R9", "done single pulse", {done_o, busy_o}, 0);
        chk(sclk_o == pol && ss_n_o, "R8", "sclk back at rest", sclk_o, pol);
        if (mid_start) begin
            repeat (3) @(negedge clk);
            chk(ss_n_o && !busy_o, "R9", "mid-frame start ignored", busy_o, 0);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(ss_n_o && !busy_o && !done_o && !mosi_o, "R1", "reset outputs",
            {ss_n_o, busy_o, done_o, mosi_o}, 4'b1000);
        rst_n = 1'b1;
        cpol_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(sclk_o == 1'b1, "R1", "idle sclk follows polarity", sclk_o, 1);
        cpol_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(sclk_o == 1'b0 && ss_n_o, "R1", "idle sclk low", sclk_o, 0);
    endtask

    task automatic t_modes();
        run_frame("R3", 1'b0, 1'b0, 8, 16'h00A5, 16'h003C, 2, 3, 1'b0);
        run_frame("R3", 1'b0, 1'b1, 8, 16'h0081, 16'h00E7, 4, 1, 1'b0);
        run_frame("R3", 1'b1, 1'b0, 8, 16'h005A, 16'h0096, 2, 3, 1'b0);
        run_frame("R3", 1'b1, 1'b1, 8, 16'h00C3, 16'h0011, 6, 2, 1'b0);
    endtask

    task automatic t_lengths();
        run_frame("R4", 1'b0, 1'b0, 4, 16'hFFF9, 16'hFFF6, 2, 3, 1'b0);
        run_frame("R4", 1'b1, 1'b1, 16, 16'hB38E, 16'h4C71, 2, 3, 1'b0);
        run_frame("R4", 1'b0, 1'b1, 2, 16'h000D, 16'h0006, 2, 3, 1'b0);
        run_frame("R4", 1'b1, 1'b0, 20, 16'h1234, 16'hFEDC, 2, 3, 1'b0);
        run_frame("R4", 1'b0, 1'b0, 11, 16'h0555, 16'h02AA, 2, 4, 1'b0);
    endtask

    task automatic t_divider();
        run_frame("R5", 1'b0, 1'b0, 5, 16'h0015, 16'h000A, 5, 1, 1'b0);
        run_frame("R5", 1'b0, 1'b0, 5, 16'h0013, 16'h000C, 10, 3, 1'b0);
        run_frame("R6", 1'b0, 1'b1, 5, 16'h0019, 16'h0006, 0, 0, 1'b0);
        run_frame("R6", 1'b1, 1'b0, 5, 16'h0001, 16'h001F, 2, 2, 1'b0);
        run_frame("R6", 1'b0, 1'b0, 5, 16'h0010, 16'h0001, 3, 0, 1'b0);
    endtask

    task automatic t_busy_ignore();
        run_frame("R9", 1'b0, 1'b0, 8, 16'h00F0, 16'h000F, 2, 3, 1'b1);
        // start held during the done cycle must not begin a new frame
        @(negedge clk);
        tx_word_i = 16'h0077; frame_len_i = 5'd6; s_len = 6; s_word = 16'h002A;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(!busy_o && ss_n_o, "R9", "start in done cycle ignored", busy_o, 0);
        chk(rx_word_o == 16'h002A, "R2", "word held after frame", rx_word_o, 16'h002A);
        @(negedge clk);
        chk(!busy_o && ss_n_o, "R9", "still idle", busy_o, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog expired: actual hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_modes();
        t_lengths();
        t_divider();
        t_busy_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule